// File: doc/BRIEF.md
# Flash Command Controller

This block sits behind a simple synchronous write port and turns single-cycle writes into the operating modes of a NOR-style flash: reading the array, reading a status byte, reading identification words, reading a short query signature, programming a word, erasing a sector, and suspending or resuming a program or an erase. Each write carries an address and a data word. The command code is taken from the low byte of the data. Two-cycle sequences (program, erase, lock) are tracked by a finite-state machine. A program or an erase occupies an internal engine for a configurable number of clock cycles, and the engine can be parked and restarted.

The storage is a small register file. Erase sets every word of a sector to all ones. Program ANDs the new data into the old word, so it can only turn ones into zeros. Reads are combinational from `rd_addr` through a multiplexer that the current read mode selects. The FSM has these states:

- `ST_READY`: idle.
- `ST_PGM_SETUP`, `ST_ERS_SETUP`, `ST_LCK_SETUP`: waiting for the second write of a sequence.
- `ST_PGM_RUN`, `ST_ERS_RUN`: the engine is counting.
- `ST_PGM_SUSP`: a program is parked.

An erase that is parked is a flag, `held_q`, which is set while the FSM sits in `ST_READY`. This lets a program run from `ST_READY` while the erase waits.

The transitions are:

- `ST_READY` to a setup state on the setup codes.
- A setup state to a run state on a valid second write, or back to `ST_READY` on a lock abort or a sequence error.
- A run state to `ST_READY` on completion.
- `ST_PGM_RUN` to `ST_PGM_SUSP` on suspend, and `ST_PGM_SUSP` back to `ST_PGM_RUN` on resume.
- `ST_ERS_RUN` to `ST_READY` with `held_q` set on suspend, and `ST_READY` back to `ST_ERS_RUN` on resume while the erase is held.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While and after reset, the controller is idle (`ready`=1) in array-read mode, all status flags are clear, no sector is locked, and every word reads FFFFh.
- R2: Writing 40h to any address and then a data word to a target address starts a program. `ready` drops at the second write and returns exactly PROG_CYCLES clock edges later, and the read mode becomes status.
- R3: A program stores old AND new, so bits only go from 1 to 0.
- R4: Writing 20h and then D0h at an address in the sector starts an erase. After ERASE_CYCLES edges, every word of that sector (sector = top SECT_W address bits) reads FFFFh, and other sectors are unchanged.
- R5: The read mode is selected as follows. Code 70h selects status: data[7:0] is the status byte and the upper bits are zero. Code 90h selects identification: address low bits 0 give MFR_ID, 1 gives DEV_ID, 2 gives the lock bit of the addressed sector in bit 0, and 3 gives zero. Code 98h selects query: addresses 16, 17 and 18 give 51h, 52h and 59h, and all others give zero. Code FFh selects array.
- R6: While a program or erase is running, only 70h and B0h take effect. Every other write, D0h included, changes neither the state nor the read mode.
- R7: B0h during a program parks it. Status bits 7 and 2 become set, and the target word keeps its old value. D0h restarts it for the remaining cycles.
- R8: B0h during an erase parks it, and status bits 7 and 6 become set. While it is parked, 70h, 90h, 98h, FFh, 40h (a full program), 60h (lock or unlock) and D0h (resume) are accepted. 20h and 50h are ignored. The erase completes only after resume.
- R9: While a program is parked, only 70h, 90h, 98h, FFh and D0h take effect. All other codes are ignored.
- R10: 60h followed by 01h locks the addressed sector, and 60h followed by D0h unlocks it. A program or erase aimed at a locked sector is aborted: status bit 1 is set, the mode becomes status and the array is unchanged.
- R11: An erase or lock setup followed by any other second code sets status bits 5 and 4, selects status mode and returns to idle.
- R12: 50h clears status bits 5, 4 and 1.

Status byte layout (R2 to R12): bit 7 ready, bit 6 erase parked, bit 5 erase or sequence error, bit 4 program or sequence error, bit 2 program parked, bit 1 lock abort, bits 3 and 0 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data; command code in bits 7:0 |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data from the mode-selected source |
| ready | output | 1 | High when the engine is not counting |

## Verification
The bench goes after commands that arrive while the engine is busy or parked. If the run states accepted FFh or 20h, the mode would fall back to array reads or a second erase would start. If 40h were accepted while a program is parked, the following status write would be taken as program data. It also runs a program inside a parked erase and checks that the parked sector stays intact until resume. A controller that let the erase counter run on would clear that sector too early. Locked-sector aborts, sequence errors and the exact busy window are checked as well. An off-by-one counter shows up as `ready` returning one edge early or late.

// File: rtl/flash_cmd_pkg.sv
`timescale 1ns/1ps
package flash_cmd_pkg;
    typedef enum logic [2:0] {
        ST_READY, ST_PGM_SETUP, ST_ERS_SETUP, ST_LCK_SETUP,
        ST_PGM_RUN, ST_PGM_SUSP, ST_ERS_RUN
    } fsm_t;

    typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_IDENT, RM_QUERY} rmode_t;

    localparam logic [7:0] OP_PGM     = 8'h40;
    localparam logic [7:0] OP_ERS     = 8'h20;
    localparam logic [7:0] OP_LOCK    = 8'h60;
    localparam logic [7:0] OP_CLR     = 8'h50;
    localparam logic [7:0] OP_STAT    = 8'h70;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_QUERY   = 8'h98;
    localparam logic [7:0] OP_READ    = 8'hFF;
    localparam logic [7:0] OP_SUSP    = 8'hB0;
    localparam logic [7:0] OP_CONFIRM = 8'hD0;
    localparam logic [7:0] OP_LOCKSET = 8'h01;
endpackage

// File: rtl/fcc_timer.sv
`timescale 1ns/1ps
module fcc_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CW'(CYCLES);
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = run && (cnt_q == CW'(1));
endmodule

// File: rtl/fcc_array.sv
`timescale 1ns/1ps
module fcc_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16,
    parameter int SECT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pgm_en,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic [DATA_W-1:0] pgm_data,
    input  logic              ers_en,
    input  logic [SECT_W-1:0] ers_sect,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] words [WORDS];

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam logic [ADDR_W-1:0] WA = ADDR_W'(w);
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q <= '1;
            else if (ers_en && WA[ADDR_W-1 -: SECT_W] == ers_sect)
                word_q <= '1;
            else if (pgm_en && pgm_addr == WA)
                word_q <= word_q & pgm_data;
        end
        assign words[w] = word_q;
    end

    assign rd_word = words[rd_addr];
endmodule

// File: rtl/fcc_rdmux.sv
`timescale 1ns/1ps
module fcc_rdmux
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W = 6,
    parameter int                DATA_W = 16,
    parameter logic [DATA_W-1:0] MFR_ID = 16'h0042,
    parameter logic [DATA_W-1:0] DEV_ID = 16'h0A17
) (
    input  rmode_t            mode,
    input  logic [DATA_W-1:0] arr_word,
    input  logic [7:0]        stat,
    input  logic              sect_lock,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        unique case (mode)
            RM_ARRAY:  rd_data = arr_word;
            RM_STATUS: rd_data[7:0] = stat;
            RM_IDENT: begin
                case (rd_addr[1:0])
                    2'd0:    rd_data = MFR_ID;
                    2'd1:    rd_data = DEV_ID;
                    2'd2:    rd_data[0] = sect_lock;
                    default: rd_data = '0;
                endcase
            end
            RM_QUERY: begin
                if (rd_addr == ADDR_W'(16))      rd_data[7:0] = 8'h51;
                else if (rd_addr == ADDR_W'(17)) rd_data[7:0] = 8'h52;
                else if (rd_addr == ADDR_W'(18)) rd_data[7:0] = 8'h59;
            end
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
`timescale 1ns/1ps
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int                ADDR_W       = 6,
    parameter int                DATA_W       = 16,
    parameter int                SECT_W       = 2,
    parameter int                PROG_CYCLES  = 8,
    parameter int                ERASE_CYCLES = 12,
    parameter logic [DATA_W-1:0] MFR_ID       = 16'h0042,
    parameter logic [DATA_W-1:0] DEV_ID       = 16'h0A17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              ready
);
    localparam int NSECT = 1 << SECT_W;

    fsm_t              st_q, st_d;
    rmode_t            mode_q, mode_d;
    logic              held_q, held_d;
    logic              ers_err_q, ers_err_d, pgm_err_q, pgm_err_d, lck_err_q, lck_err_d;
    logic [NSECT-1:0]  lock_q, lock_d;
    logic [ADDR_W-1:0] paddr_q, paddr_d;
    logic [DATA_W-1:0] pdata_q, pdata_d;
    logic [SECT_W-1:0] esect_q, esect_d;
    logic              pgm_ld, ers_ld, pgm_fire, ers_fire, pgm_done, ers_done;
    logic [7:0]        cmd, stat;
    logic [SECT_W-1:0] wsect;
    logic [DATA_W-1:0] arr_word;

    assign cmd   = wr_data[7:0];
    assign wsect = wr_addr[ADDR_W-1 -: SECT_W];

    // next-state and strobe logic
    always_comb begin
        st_d = st_q;  mode_d = mode_q;  held_d = held_q;
        ers_err_d = ers_err_q;  pgm_err_d = pgm_err_q;  lck_err_d = lck_err_q;
        lock_d = lock_q;  paddr_d = paddr_q;  pdata_d = pdata_q;  esect_d = esect_q;
        pgm_ld = 1'b0;  ers_ld = 1'b0;  pgm_fire = 1'b0;  ers_fire = 1'b0;
        unique case (st_q)
            ST_READY: if (wr_en) begin
                if (held_q) begin
                    unique case (cmd)
                        OP_STAT:    mode_d = RM_STATUS;
                        OP_IDENT:   mode_d = RM_IDENT;
                        OP_QUERY:   mode_d = RM_QUERY;
                        OP_READ:    mode_d = RM_ARRAY;
                        OP_PGM:     st_d = ST_PGM_SETUP;
                        OP_LOCK:    st_d = ST_LCK_SETUP;
                        OP_CONFIRM: begin st_d = ST_ERS_RUN; held_d = 1'b0; mode_d = RM_STATUS; end
                        default: ;
                    endcase
                end else begin
                    unique case (cmd)
                        OP_STAT:  mode_d = RM_STATUS;
                        OP_IDENT: mode_d = RM_IDENT;
                        OP_QUERY: mode_d = RM_QUERY;
                        OP_READ:  mode_d = RM_ARRAY;
                        OP_CLR:   begin ers_err_d = 1'b0; pgm_err_d = 1'b0; lck_err_d = 1'b0; end
                        OP_PGM:   st_d = ST_PGM_SETUP;
                        OP_ERS:   st_d = ST_ERS_SETUP;
                        OP_LOCK:  st_d = ST_LCK_SETUP;
                        default: ;
                    endcase
                end
            end
            ST_PGM_SETUP: if (wr_en) begin
                mode_d = RM_STATUS;
                if (lock_q[wsect]) begin
                    lck_err_d = 1'b1;  st_d = ST_READY;
                end else begin
                    paddr_d = wr_addr;  pdata_d = wr_data;  pgm_ld = 1'b1;  st_d = ST_PGM_RUN;
                end
            end
            ST_ERS_SETUP: if (wr_en) begin
                mode_d = RM_STATUS;  st_d = ST_READY;
                if (cmd != OP_CONFIRM) begin
                    ers_err_d = 1'b1;  pgm_err_d = 1'b1;
                end else if (lock_q[wsect]) begin
                    lck_err_d = 1'b1;
                end else begin
                    esect_d = wsect;  ers_ld = 1'b1;  st_d = ST_ERS_RUN;
                end
            end
            ST_LCK_SETUP: if (wr_en) begin
                st_d = ST_READY;
                if (cmd == OP_LOCKSET)      lock_d[wsect] = 1'b1;
                else if (cmd == OP_CONFIRM) lock_d[wsect] = 1'b0;
                else begin
                    ers_err_d = 1'b1;  pgm_err_d = 1'b1;  mode_d = RM_STATUS;
                end
            end
            ST_PGM_RUN: begin
                if (pgm_done) begin
                    pgm_fire = 1'b1;  st_d = ST_READY;
                end else if (wr_en && cmd == OP_STAT) begin
                    mode_d = RM_STATUS;
                end else if (wr_en && cmd == OP_SUSP) begin
                    mode_d = RM_STATUS;  st_d = ST_PGM_SUSP;
                end
            end
            ST_PGM_SUSP: if (wr_en) begin
                unique case (cmd)
                    OP_STAT:    mode_d = RM_STATUS;
                    OP_IDENT:   mode_d = RM_IDENT;
                    OP_QUERY:   mode_d = RM_QUERY;
                    OP_READ:    mode_d = RM_ARRAY;
                    OP_CONFIRM: begin mode_d = RM_STATUS; st_d = ST_PGM_RUN; end
                    default: ;
                endcase
            end
            ST_ERS_RUN: begin
                if (ers_done) begin
                    ers_fire = 1'b1;  st_d = ST_READY;
                end else if (wr_en && cmd == OP_STAT) begin
                    mode_d = RM_STATUS;
                end else if (wr_en && cmd == OP_SUSP) begin
                    mode_d = RM_STATUS;  held_d = 1'b1;  st_d = ST_READY;
                end
            end
            default: st_d = ST_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_READY;  mode_q <= RM_ARRAY;  held_q <= 1'b0;
            ers_err_q <= 1'b0;  pgm_err_q <= 1'b0;  lck_err_q <= 1'b0;
            lock_q <= '0;  paddr_q <= '0;  pdata_q <= '0;  esect_q <= '0;
        end else begin
            st_q <= st_d;  mode_q <= mode_d;  held_q <= held_d;
            ers_err_q <= ers_err_d;  pgm_err_q <= pgm_err_d;  lck_err_q <= lck_err_d;
            lock_q <= lock_d;  paddr_q <= paddr_d;  pdata_q <= pdata_d;  esect_q <= esect_d;
        end
    end

    // outputs
    always_comb begin
        ready = !(st_q == ST_PGM_RUN || st_q == ST_ERS_RUN);
        stat  = {ready, held_q, ers_err_q, pgm_err_q, 1'b0,
                 st_q == ST_PGM_SUSP, lck_err_q, 1'b0};
    end

    fcc_timer #(.CYCLES(PROG_CYCLES)) i_pgm_timer (
        .clk(clk), .rst_n(rst_n), .load(pgm_ld), .run(st_q == ST_PGM_RUN), .done(pgm_done));

    fcc_timer #(.CYCLES(ERASE_CYCLES)) i_ers_timer (
        .clk(clk), .rst_n(rst_n), .load(ers_ld), .run(st_q == ST_ERS_RUN), .done(ers_done));

    fcc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) i_array (
        .clk(clk), .rst_n(rst_n), .pgm_en(pgm_fire), .pgm_addr(paddr_q), .pgm_data(pdata_q),
        .ers_en(ers_fire), .ers_sect(esect_q), .rd_addr(rd_addr), .rd_word(arr_word));

    fcc_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) i_rdmux (
        .mode(mode_q), .arr_word(arr_word), .stat(stat),
        .sect_lock(lock_q[rd_addr[ADDR_W-1 -: SECT_W]]), .rd_addr(rd_addr), .rd_data(rd_data));
endmodule

// File: rtl/fcc_checker.sv
`timescale 1ns/1ps
module fcc_checker
    import flash_cmd_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   wr_en,
    input logic [7:0] cmd,
    input fsm_t   st,
    input rmode_t mode,
    input logic   held,
    input logic   ers_err,
    input logic   pgm_err,
    input logic   lck_err,
    input logic   pgm_done
);
    AST_RESET_TO_ARRAY: assert property (@(posedge clk)
        !rst_n |=> (mode == RM_ARRAY && st == ST_READY && !held)); // R1

    AST_DONE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_done |-> st == ST_PGM_RUN); // R2

    AST_RUN_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PGM_RUN && wr_en && !pgm_done && cmd != OP_STAT && cmd != OP_SUSP)
        |=> (st == ST_PGM_RUN && $stable(mode))); // R6

    AST_HELD_NOT_ERASING: assert property (@(posedge clk) disable iff (!rst_n)
        held |-> st != ST_ERS_RUN); // R8

    AST_HELD_REJECTS_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READY && held && wr_en && (cmd == OP_ERS || cmd == OP_CLR))
        |=> (st == ST_READY && held && $stable({ers_err, pgm_err, lck_err}))); // R8

    AST_PSUSP_REJECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PGM_SUSP && wr_en &&
         (cmd == OP_PGM || cmd == OP_ERS || cmd == OP_LOCK || cmd == OP_CLR))
        |=> (st == ST_PGM_SUSP && $stable({ers_err, pgm_err, lck_err}))); // R9

    AST_SEQ_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERS_SETUP && wr_en && cmd != OP_CONFIRM)
        |=> (ers_err && pgm_err && mode == RM_STATUS && st == ST_READY)); // R11
endmodule

bind flash_cmd_ctrl fcc_checker i_fcc_checker (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd(wr_data[7:0]), .st(st_q),
    .mode(mode_q), .held(held_q), .ers_err(ers_err_q), .pgm_err(pgm_err_q),
    .lck_err(lck_err_q), .pgm_done(pgm_done));

// File: tb/test_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module test_flash_cmd_ctrl;
    localparam int          AW   = 6;
    localparam int          DW   = 16;
    localparam int          PCYC = 8;
    localparam int          ECYC = 12;
    localparam logic [15:0] MFR  = 16'h0042;
    localparam logic [15:0] DEV  = 16'h0A17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          ready;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    logic [15:0] model [64];

    always #10 clk = ~clk;

    flash_cmd_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(2), .PROG_CYCLES(PCYC),
                     .ERASE_CYCLES(ECYC), .MFR_ID(MFR), .DEV_ID(DEV)) i_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ready(ready));

    function automatic logic [15:0] sb(input bit rdy, input bit es, input bit ee,
                                       input bit pe, input bit ps, input bit le);
        return {8'h00, rdy, es, ee, pe, 1'b0, ps, le, 1'b0};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_rd(input string req, input logic [AW-1:0] a, input logic [15:0] exp);
        @(negedge clk);
        rd_addr = a;
        #1;
        chk(req, rd_data, exp);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 2000; i++) begin
            if (ready) break;
            @(negedge clk);
        end
    endtask

    task automatic do_prog(input logic [AW-1:0] a, input logic [15:0] d);
        wr(0, 16'h40); wr(a, d); wait_ready(); wr(0, 16'hFF);
        model[a] = model[a] & d;
    endtask

    task automatic do_erase(input logic [1:0] s);
        wr(0, 16'h20); wr({s, 4'h0}, 16'hD0); wait_ready(); wr(0, 16'hFF);
        for (int i = 0; i < 16; i++) model[{s, 4'(i)}] = 16'hFFFF;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed_val;
        seed_val = $urandom(32'd2718);
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready in reset", {15'd0, ready}, 16'd1);
        rst_n = 1'b1;
        chk_rd("R1 erased word", 6'd5, 16'hFFFF);
        chk("R1 ready", {15'd0, ready}, 16'd1);
        wr(0, 16'h70);
        chk_rd("R1 status clear", 6'd0, sb(1,0,0,0,0,0));
        wr(0, 16'hFF);

        // R2 busy window
        wr(0, 16'h40); wr(6'd3, 16'h1234);
        chk("R2 busy after write", {15'd0, ready}, 16'd0);
        repeat (PCYC - 1) @(negedge clk);
        chk("R2 busy last cycle", {15'd0, ready}, 16'd0);
        @(negedge clk);
        chk("R2 ready after window", {15'd0, ready}, 16'd1);
        model[3] = 16'h1234;
        chk_rd("R2 status mode", 6'd3, sb(1,0,0,0,0,0));
        wr(0, 16'hFF);
        chk_rd("R2 programmed word", 6'd3, model[3]);

        // R3 only clears bits
        do_prog(6'd3, 16'hFF0F);
        chk_rd("R3 and of words", 6'd3, 16'h1204);

        // R4 erase
        do_prog(6'h12, 16'h00FF);
        do_erase(2'd0);
        chk_rd("R4 erased word", 6'd3, 16'hFFFF);
        chk_rd("R4 sector end", 6'h0F, 16'hFFFF);
        chk_rd("R4 other sector kept", 6'h12, 16'h00FF);

        // R5 read modes
        wr(0, 16'h90);
        chk_rd("R5 ident mfr", 6'h10, MFR);
        chk_rd("R5 ident dev", 6'h01, DEV);
        chk_rd("R5 ident lock", 6'h02, 16'h0000);
        wr(0, 16'h98);
        chk_rd("R5 query Q", 6'd16, 16'h0051);
        chk_rd("R5 query R", 6'd17, 16'h0052);
        chk_rd("R5 query Y", 6'd18, 16'h0059);
        chk_rd("R5 query other", 6'd5, 16'h0000);
        wr(0, 16'hFF);
        chk_rd("R5 back to array", 6'h12, 16'h00FF);

        // R6 commands ignored while running
        wr(0, 16'h40); wr(6'h20, 16'h0F0F);
        wr(0, 16'hFF);
        chk_rd("R6 FF ignored while busy", 6'h20, sb(0,0,0,0,0,0));
        wr(6'h20, 16'h20);
        wait_ready();
        chk_rd("R6 no side effect", 6'h20, sb(1,0,0,0,0,0));
        wr(0, 16'hFF);
        model[6'h20] = 16'h0F0F;
        chk_rd("R6 program result", 6'h20, 16'h0F0F);

        // R7 / R9 program suspend
        wr(0, 16'h40); wr(6'h21, 16'h00F0);
        wr(0, 16'hB0);
        chk_rd("R7 suspended status", 6'h0, sb(1,0,0,0,1,0));
        wr(0, 16'hFF);
        chk_rd("R7 target untouched", 6'h21, 16'hFFFF);
        wr(6'h22, 16'h40);
        wr(0, 16'h70);
        chk_rd("R9 setup ignored", 6'h0, sb(1,0,0,0,1,0));
        wr(0, 16'hD0);
        chk_rd("R7 resumed busy", 6'h0, sb(0,0,0,0,0,0));
        wait_ready();
        wr(0, 16'hFF);
        model[6'h21] = 16'h00F0;
        chk_rd("R7 program done", 6'h21, 16'h00F0);
        chk_rd("R9 no stray program", 6'h22, 16'hFFFF);

        // R8 erase suspend
        wr(0, 16'h20); wr(6'h20, 16'hD0);
        wr(0, 16'hB0);
        chk_rd("R8 erase parked", 6'h0, sb(1,1,0,0,0,0));
        wr(6'h30, 16'h20);
        wr(0, 16'h70);
        chk_rd("R8 second erase rejected", 6'h0, sb(1,1,0,0,0,0));
        wr(0, 16'h40); wr(6'h05, 16'hAAAA);
        wait_ready();
        chk_rd("R8 program in park", 6'h0, sb(1,1,0,0,0,0));
        wr(0, 16'hFF);
        model[5] = model[5] & 16'hAAAA;
        chk_rd("R8 parked sector intact", 6'h20, 16'h0F0F);
        chk_rd("R8 nested program", 6'h05, model[5]);
        wr(0, 16'hD0);
        chk_rd("R8 erase resumed", 6'h0, sb(0,0,0,0,0,0));
        wait_ready();
        wr(0, 16'hFF);
        for (int i = 0; i < 16; i++) model[{2'd2, 4'(i)}] = 16'hFFFF;
        chk_rd("R8 erase finished", 6'h20, 16'hFFFF);
        chk_rd("R8 erase finished b", 6'h21, 16'hFFFF);

        // R10 locking
        wr(0, 16'h60); wr(6'h30, 16'h01);
        wr(0, 16'h40); wr(6'h31, 16'h0000);
        chk_rd("R10 lock abort", 6'h0, sb(1,0,0,0,0,1));
        wr(0, 16'hFF);
        chk_rd("R10 locked word kept", 6'h31, 16'hFFFF);
        wr(0, 16'h90);
        chk_rd("R10 lock bit shown", 6'h32, 16'h0001);
        chk_rd("R10 other sector open", 6'h02, 16'h0000);
        wr(0, 16'h50); wr(0, 16'h70);
        chk_rd("R12 clear", 6'h0, sb(1,0,0,0,0,0));
        wr(0, 16'h20); wr(6'h30, 16'hD0);
        chk_rd("R10 erase of locked", 6'h0, sb(1,0,0,0,0,1));
        wr(0, 16'h50);
        wr(0, 16'h60); wr(6'h30, 16'hD0);
        do_prog(6'h31, 16'h1111);
        chk_rd("R10 unlocked program", 6'h31, 16'h1111);

        // R11 / R12 sequence errors
        wr(0, 16'h20); wr(0, 16'h33);
        chk_rd("R11 erase seq error", 6'h0, sb(1,0,1,1,0,0));
        wr(0, 16'h50);
        chk_rd("R12 clear errors", 6'h0, sb(1,0,0,0,0,0));
        wr(0, 16'h60); wr(0, 16'h77);
        chk_rd("R11 lock seq error", 6'h0, sb(1,0,1,1,0,0));
        wr(0, 16'h50); wr(0, 16'hFF);

        // R3 / R4 random operations against the model
        for (int it = 0; it < 40; it++) begin
            if ($urandom_range(0, 9) < 8) begin
                logic [AW-1:0] a;
                logic [15:0] d;
                a = AW'($urandom_range(0, 63));
                d = 16'($urandom);
                do_prog(a, d);
                chk_rd("R3 random program", a, model[a]);
            end else begin
                logic [1:0] s;
                s = 2'($urandom_range(0, 3));
                do_erase(s);
            end
            for (int k = 0; k < 3; k++) begin
                logic [AW-1:0] ra;
                ra = AW'($urandom_range(0, 63));
                chk_rd("R4 random readback", ra, model[ra]);
            end
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule